// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block holds a small bank of programmable windows that map addresses seen on the local system bus onto addresses on the link side. Software programs each window through a 32-bit register port. A window has an enable bit, a kind (configuration, I/O or memory), a 64-bit size mask, a 64-bit local base and a 64-bit remote address. The size mask is written as the bitwise inverse of (size - 1). Its upper half sits in a separate extension register, and windows are never smaller than 1 KB.

A lookup presents a 64-bit local address on the lookup port. One clock later the block reports whether a window matched, which window it was, its kind, and the translated remote address. When several windows cover the address, the lowest-numbered one is used. For configuration-kind windows, the block also splits the translated address into bus, device and function numbers for the request builder downstream.

Top module: `ob_xlate_windows`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, every window is disabled, and a lookup misses.
- R2: Main word 0 of a window is its control word. Bit 0 is enable, bits [2:1] are the kind (0 config, 1 I/O, 2 memory, 3 reserved), and bits [31:10] are bits [31:10] of the size mask. Bits [9:3] are not stored and read as zero.
- R3: Bits [1:0] of the local base low word are forced to zero on write and read back as zero.
- R4: An enabled window matches when (addr AND mask) equals (base AND mask). The 64-bit mask is {size-high word, control[31:10], ten zero bits}, and the base is {base-high word, base-low word}.
- R5: On a match, the result address is (remote AND mask) OR (addr AND NOT mask), with remote = {remote-high word, remote-low word]. Address bits [9:0] always pass through unchanged.
- R6: When more than one window matches, the result reports the lowest-numbered matching window.
- R7: A miss reports hit 0, window index 0, kind 0 and address 0.
- R8: A register access is ignored, and reads zero, in any of these cases: its window slot is at or above NUM_WIN, its address is not word aligned (addr[1:0] not 0), or it falls in the unmapped block addr[9:8] = 3.
- R9: When the matched window has config kind, the bus, device and function outputs carry translated-address bits [31:24], [23:19] and [18:16]. For any other result they are zero.
- R10: The result appears with res_valid high exactly one clock after lk_req is sampled high, and res_valid is low otherwise. A lookup in the same cycle as a register write uses the window settings from before that write.
- R11: A disabled window never matches, even when its base and mask cover the address.
- R12: Register byte map: main words of window w at 16*w + 4*k, with k = 0 control, 1 base low, 2 remote low, 3 remote high. Size-high word of window w at 0x100 + 4*w. Base-high word at 0x200 + 4*w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address, also used for reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 64 | Local address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_idx | output | $clog2(NUM_WIN) | Matched window number |
| res_type | output | 2 | Kind of the matched window |
| res_addr | output | 64 | Translated remote address |
| res_bus | output | 8 | Bus number for config-kind results |
| res_dev | output | 5 | Device number for config-kind results |
| res_fn | output | 3 | Function number for config-kind results |

## Verification
A register write and a lookup can land on the same clock edge, and the lookup may hit the very window being rewritten. The bench provokes this by disabling window 0 in the same cycle as a lookup that window 0 covers. The result must still name window 0 with its old translation. A second lookup of the same address must then fall through to the overlapping window 1. A second collision case is several windows matching one address at once; that is judged by the reported index, which must be the lowest matching window.

// File: rtl/ob_win_pkg.sv
// Shared constants and types for the outbound translation windows.
// Assumes a 32-bit register port and 64-bit addresses on both sides.
package ob_win_pkg;
    localparam int LA_W       = 64;   // local and remote address width
    localparam int WORD_W     = 32;   // register word width
    localparam int REG_AW     = 10;   // register byte address width
    localparam int MASK_FLOOR = 10;   // mask bits below this are always zero

    localparam logic [1:0] BLK_MAIN  = 2'd0;
    localparam logic [1:0] BLK_SIZEH = 2'd1;
    localparam logic [1:0] BLK_BASEH = 2'd2;

    localparam logic [WORD_W-1:0] CTRL_KEEP = 32'hFFFF_FC07;

    typedef enum logic [1:0] {
        WT_CFG = 2'd0,
        WT_IO  = 2'd1,
        WT_MEM = 2'd2,
        WT_RSV = 2'd3
    } win_kind_e;
endpackage

// File: rtl/ob_win_regs.sv
// Register storage for all windows plus the combinational read mux.
// Assumes NUM_WIN between 2 and 16; slots at or above NUM_WIN and
// unaligned addresses are neither written nor read.
module ob_win_regs
    import ob_win_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [NUM_WIN-1:0] en_o,
    output win_kind_e         kind_o   [NUM_WIN],
    output logic [LA_W-1:0]   mask_o   [NUM_WIN],
    output logic [LA_W-1:0]   base_o   [NUM_WIN],
    output logic [LA_W-1:0]   remote_o [NUM_WIN]
);
    logic [1:0] blk;
    logic [3:0] mslot;
    logic [1:0] mreg;
    logic [5:0] xslot;
    logic       aligned;
    logic       main_ok, szh_ok, bhi_ok;

    // address decode into block, slot and word
    assign blk     = addr[9:8];
    assign mslot   = addr[7:4];
    assign mreg    = addr[3:2];
    assign xslot   = addr[7:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign main_ok = aligned && (blk == BLK_MAIN)  && (int'(mslot) < NUM_WIN);
    assign szh_ok  = aligned && (blk == BLK_SIZEH) && (int'(xslot) < NUM_WIN);
    assign bhi_ok  = aligned && (blk == BLK_BASEH) && (int'(xslot) < NUM_WIN);

    logic [WORD_W-1:0] ctrl_a [NUM_WIN];
    logic [WORD_W-1:0] blo_a  [NUM_WIN];
    logic [WORD_W-1:0] rlo_a  [NUM_WIN];
    logic [WORD_W-1:0] rhi_a  [NUM_WIN];
    logic [WORD_W-1:0] szh_a  [NUM_WIN];
    logic [WORD_W-1:0] bhi_a  [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [3:0] MS = 4'(g);
        localparam logic [5:0] XS = 6'(g);
        logic [WORD_W-1:0] ctrl_q, blo_q, rlo_q, rhi_q, szh_q, bhi_q;
        logic              sel_main, sel_szh, sel_bhi;

        assign sel_main = wr && main_ok && (mslot == MS);
        assign sel_szh  = wr && szh_ok  && (xslot == XS);
        assign sel_bhi  = wr && bhi_ok  && (xslot == XS);

        // per-window register update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q <= '0;
                blo_q  <= '0;
                rlo_q  <= '0;
                rhi_q  <= '0;
                szh_q  <= '0;
                bhi_q  <= '0;
            end else begin
                if (sel_main) begin
                    case (mreg)
                        2'd0:    ctrl_q <= wdata & CTRL_KEEP;
                        2'd1:    blo_q  <= {wdata[WORD_W-1:2], 2'b00};
                        2'd2:    rlo_q  <= wdata;
                        default: rhi_q  <= wdata;
                    endcase
                end
                if (sel_szh) szh_q <= wdata;
                if (sel_bhi) bhi_q <= wdata;
            end
        end

        assign ctrl_a[g]   = ctrl_q;
        assign blo_a[g]    = blo_q;
        assign rlo_a[g]    = rlo_q;
        assign rhi_a[g]    = rhi_q;
        assign szh_a[g]    = szh_q;
        assign bhi_a[g]    = bhi_q;
        assign en_o[g]     = ctrl_q[0];
        assign kind_o[g]   = win_kind_e'(ctrl_q[2:1]);
        assign mask_o[g]   = {szh_q, ctrl_q[WORD_W-1:MASK_FLOOR], {MASK_FLOOR{1'b0}}};
        assign base_o[g]   = {bhi_q, blo_q};
        assign remote_o[g] = {rhi_q, rlo_q};
    end

    // read mux, zero for anything unmapped
    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (main_ok && (mslot == 4'(w))) begin
                case (mreg)
                    2'd0:    rdata = ctrl_a[w];
                    2'd1:    rdata = blo_a[w];
                    2'd2:    rdata = rlo_a[w];
                    default: rdata = rhi_a[w];
                endcase
            end
            if (szh_ok && (xslot == 6'(w))) rdata = szh_a[w];
            if (bhi_ok && (xslot == 6'(w))) rdata = bhi_a[w];
        end
    end
endmodule

// File: rtl/ob_win_match.sv
// One masked comparator per window; flags every enabled window that
// covers the lookup address. Purely combinational.
module ob_win_match
    import ob_win_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [LA_W-1:0]    addr,
    input  logic [NUM_WIN-1:0] en,
    input  logic [LA_W-1:0]    mask [NUM_WIN],
    input  logic [LA_W-1:0]    base [NUM_WIN],
    output logic [NUM_WIN-1:0] hit_vec
);
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        // masked equality against this window's base
        assign hit_vec[g] = en[g] && ((addr & mask[g]) == (base[g] & mask[g]));
    end
endmodule

// File: rtl/ob_win_pick.sv
// Picks the lowest-numbered matching window and forms the translated
// address from its remote address and mask. Combinational.
module ob_win_pick
    import ob_win_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic [LA_W-1:0]    addr,
    input  logic [NUM_WIN-1:0] hit_vec,
    input  win_kind_e          kind   [NUM_WIN],
    input  logic [LA_W-1:0]    mask   [NUM_WIN],
    input  logic [LA_W-1:0]    remote [NUM_WIN],
    output logic               any_hit,
    output logic [IDX_W-1:0]   sel_idx,
    output win_kind_e          sel_kind,
    output logic [LA_W-1:0]    xl_addr
);
    logic [LA_W-1:0] sel_mask, sel_rem;

    // scan from the top so the lowest index is the last to claim
    always_comb begin
        any_hit  = 1'b0;
        sel_idx  = '0;
        sel_kind = WT_CFG;
        sel_mask = '0;
        sel_rem  = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                any_hit  = 1'b1;
                sel_idx  = IDX_W'(w);
                sel_kind = kind[w];
                sel_mask = mask[w];
                sel_rem  = remote[w];
            end
        end
        xl_addr = any_hit ? ((sel_rem & sel_mask) | (addr & ~sel_mask)) : '0;
    end
endmodule

// File: rtl/ob_xlate_windows.sv
// Top of the outbound translation window bank: register file, parallel
// window compare, priority pick and a one-cycle result register.
// Assumes NUM_WIN between 2 and 16 and a synchronous active-low reset.
module ob_xlate_windows
    import ob_win_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [9:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_req,
    input  logic [63:0]       lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_idx,
    output logic [1:0]        res_type,
    output logic [63:0]       res_addr,
    output logic [7:0]        res_bus,
    output logic [4:0]        res_dev,
    output logic [2:0]        res_fn
);
    logic [NUM_WIN-1:0] en_w;
    win_kind_e          kind_w   [NUM_WIN];
    logic [LA_W-1:0]    mask_w   [NUM_WIN];
    logic [LA_W-1:0]    base_w   [NUM_WIN];
    logic [LA_W-1:0]    remote_w [NUM_WIN];
    logic [NUM_WIN-1:0] hit_vec;
    logic               any_hit;
    logic [IDX_W-1:0]   sel_idx;
    win_kind_e          sel_kind;
    logic [LA_W-1:0]    xl_addr;
    logic               is_cfg;

    ob_win_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .en_o     (en_w),
        .kind_o   (kind_w),
        .mask_o   (mask_w),
        .base_o   (base_w),
        .remote_o (remote_w)
    );

    ob_win_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr    (lk_addr),
        .en      (en_w),
        .mask    (mask_w),
        .base    (base_w),
        .hit_vec (hit_vec)
    );

    ob_win_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .addr     (lk_addr),
        .hit_vec  (hit_vec),
        .kind     (kind_w),
        .mask     (mask_w),
        .remote   (remote_w),
        .any_hit  (any_hit),
        .sel_idx  (sel_idx),
        .sel_kind (sel_kind),
        .xl_addr  (xl_addr)
    );

    assign is_cfg = any_hit && (sel_kind == WT_CFG);

    // result register, loaded on each lookup request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
            res_type  <= '0;
            res_addr  <= '0;
            res_bus   <= '0;
            res_dev   <= '0;
            res_fn    <= '0;
        end else begin
            res_valid <= lk_req;
            if (lk_req) begin
                res_hit  <= any_hit;
                res_idx  <= sel_idx;
                res_type <= sel_kind;
                res_addr <= xl_addr;
                res_bus  <= is_cfg ? xl_addr[31:24] : 8'd0;
                res_dev  <= is_cfg ? xl_addr[23:19] : 5'd0;
                res_fn   <= is_cfg ? xl_addr[18:16] : 3'd0;
            end
        end
    end
endmodule

// File: rtl/ob_xlate_windows_chk.sv
// Property checker for the translation window bank, bound to the top.
// Observes ports only.
module ob_xlate_windows_chk #(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [9:0]       reg_addr,
    input logic [31:0]      reg_rdata,
    input logic             lk_req,
    input logic [9:0]       lk_low,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_idx,
    input logic [1:0]       res_type,
    input logic [63:0]      res_addr,
    input logic [7:0]       res_bus,
    input logic [4:0]       res_dev,
    input logic [2:0]       res_fn
);
    AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> res_valid); // R10
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !res_valid); // R10
    AST_MISS_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_addr == '0 && res_idx == '0 && res_type == 2'd0)); // R7
    AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (res_addr[9:0] == $past(lk_low))); // R5
    AST_BDF_CFG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_type != 2'd0) |-> (res_bus == 8'd0 && res_dev == 5'd0 && res_fn == 3'd0)); // R9
    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[9:8] == 2'b11) |-> (reg_rdata == 32'd0)); // R8
endmodule

bind ob_xlate_windows ob_xlate_windows_chk #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .lk_req    (lk_req),
    .lk_low    (lk_addr[9:0]),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_idx   (res_idx),
    .res_type  (res_type),
    .res_addr  (res_addr),
    .res_bus   (res_bus),
    .res_dev   (res_dev),
    .res_fn    (res_fn)
);

// File: tb/sim_ob_xlate_windows.sv
// Self-checking bench: a vector table of lookups, then directed tests.
module sim_ob_xlate_windows;
    localparam int NW = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [9:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          lk_req = 1'b0;
    logic [63:0]   lk_addr = '0;
    logic          res_valid, res_hit;
    logic [IW-1:0] res_idx;
    logic [1:0]    res_type;
    logic [63:0]   res_addr;
    logic [7:0]    res_bus;
    logic [4:0]    res_dev;
    logic [2:0]    res_fn;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ob_xlate_windows #(.NUM_WIN(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
        .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit),
        .res_idx(res_idx), .res_type(res_type), .res_addr(res_addr),
        .res_bus(res_bus), .res_dev(res_dev), .res_fn(res_fn)
    );

    typedef struct packed {
        logic [63:0]   a;
        logic          hit;
        logic [IW-1:0] idx;
        logic [1:0]    kind;
        logic [63:0]   x;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        '{64'h0000_0000_8000_0123, 1'b1, 3'd0, 2'd2, 64'h0000_0040_1234_5123},
        '{64'h0000_0000_8000_1FF0, 1'b1, 3'd1, 2'd1, 64'h0000_0000_00A0_1FF0},
        '{64'h0000_0000_8001_0000, 1'b0, 3'd0, 2'd0, 64'h0},
        '{64'h0000_0002_0312_8044, 1'b1, 3'd2, 2'd0, 64'h0000_0000_1312_8044},
        '{64'h0000_0010_ABCD_1234, 1'b1, 3'd3, 2'd2, 64'h0000_0020_ABCD_1234},
        '{64'h0000_0003_0000_0010, 1'b0, 3'd0, 2'd0, 64'h0},
        '{64'h0000_0000_4000_07FF, 1'b1, 3'd7, 2'd2, 64'h0000_0000_0000_0BFF},
        '{64'h0000_0000_4000_0800, 1'b0, 3'd0, 2'd0, 64'h0},
        '{64'h0000_0001_8000_0000, 1'b0, 3'd0, 2'd0, 64'h0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [9:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, {32'd0, reg_rdata}, {32'd0, exp});
    endtask

    task automatic look(input logic [63:0] a);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic prog(input int w, input logic [31:0] ctrl, input logic [31:0] szh,
                        input logic [31:0] blo, input logic [31:0] bhi,
                        input logic [31:0] rlo, input logic [31:0] rhi);
        wr(10'(16 * w),          ctrl);
        wr(10'(16 * w + 4),      blo);
        wr(10'(16 * w + 8),      rlo);
        wr(10'(16 * w + 12),     rhi);
        wr(10'(256 + 4 * w),     szh);
        wr(10'(512 + 4 * w),     bhi);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd("R1 ctrl w0 after reset", 10'h000, 32'h0);
        rd("R1 size-high w0 after reset", 10'h100, 32'h0);
        look(64'h0);
        chk("R1 valid after lookup", {63'd0, res_valid}, 64'd1);
        chk("R1 miss after reset", {63'd0, res_hit}, 64'd0);

        // R2: control field storage
        wr(10'h050, 32'hFFFF_FFFF);
        rd("R2 ctrl keeps only defined bits", 10'h050, 32'hFFFF_FC07);
        wr(10'h050, 32'h0);

        // program windows
        prog(0, 32'hFFFF_F005, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0, 32'h1234_5ABC, 32'h0000_0040);
        prog(1, 32'hFFFF_0003, 32'hFFFF_FFFF, 32'h8000_0003, 32'h0, 32'h00A0_0000, 32'h0);
        prog(2, 32'hF000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 32'h2, 32'h1000_0000, 32'h0);
        prog(3, 32'h0000_0005, 32'hFFFF_FFFF, 32'h0000_0000, 32'h10, 32'hDEAD_0000, 32'h20);
        prog(4, 32'hFFFF_F004, 32'hFFFF_FFFF, 32'h0000_0000, 32'h3, 32'h0, 32'h0);
        prog(7, 32'hFFFF_FC05, 32'hFFFF_FFFF, 32'h4000_0400, 32'h0, 32'h0000_0800, 32'h0);

        // R3: base low bits forced to zero
        rd("R3 base low readback", 10'h014, 32'h8000_0000);

        // R12: register map strides
        rd("R12 remote low w7", 10'h078, 32'h0000_0800);
        rd("R12 base high w2", 10'h208, 32'h0000_0002);
        rd("R12 size high w3", 10'h10C, 32'hFFFF_FFFF);

        // R8: out-of-range slot, unaligned and unmapped accesses
        wr(10'h090, 32'hFFFF_FFFF);
        rd("R8 slot 9 reads zero", 10'h090, 32'h0);
        rd("R8 slot 9 did not alias w1", 10'h010, 32'hFFFF_0003);
        wr(10'h124, 32'h1234_5678);
        rd("R8 ext slot 9 reads zero", 10'h124, 32'h0);
        rd("R8 ext slot 9 did not alias w1", 10'h104, 32'hFFFF_FFFF);
        wr(10'h009, 32'h0);
        rd("R8 unaligned write ignored", 10'h008, 32'h1234_5ABC);
        rd("R8 unaligned read zero", 10'h009, 32'h0);
        wr(10'h300, 32'hFFFF_FFFF);
        rd("R8 unmapped block reads zero", 10'h300, 32'h0);

        // vector table: R4 match, R5 translate, R6 priority, R7 miss, R11 disabled
        for (int i = 0; i < NV; i++) begin
            look(VT[i].a);
            chk($sformatf("R4/R11 vector %0d hit", i), {63'd0, res_hit}, {63'd0, VT[i].hit});
            chk($sformatf("R6 vector %0d index", i), {61'd0, res_idx}, {61'd0, VT[i].idx});
            chk($sformatf("R7 vector %0d kind", i), {62'd0, res_type}, {62'd0, VT[i].kind});
            chk($sformatf("R5 vector %0d address", i), res_addr, VT[i].x);
        end

        // R9: bus/device/function split for a config-kind window
        look(64'h0000_0002_0312_8044);
        chk("R9 bus", {56'd0, res_bus}, 64'h13);
        chk("R9 device", {59'd0, res_dev}, 64'd2);
        chk("R9 function", {61'd0, res_fn}, 64'd2);
        look(64'h0000_0000_8000_0123);
        chk("R9 bus zero for memory kind", {56'd0, res_bus}, 64'd0);

        // R10: write and lookup in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 10'h000; reg_wdata = 32'h0;
        lk_req = 1'b1; lk_addr = 64'h0000_0000_8000_0123;
        @(negedge clk);
        reg_wr = 1'b0; lk_req = 1'b0;
        chk("R10 same-cycle lookup sees old window", {63'd0, res_hit}, 64'd1);
        chk("R10 same-cycle lookup index", {61'd0, res_idx}, 64'd0);
        chk("R10 same-cycle lookup address", res_addr, 64'h0000_0040_1234_5123);
        @(negedge clk);
        chk("R10 valid drops without request", {63'd0, res_valid}, 64'd0);
        look(64'h0000_0000_8000_0123);
        chk("R10 later lookup falls to w1", {61'd0, res_idx}, 64'd1);
        chk("R11 disabled w0 skipped, address", res_addr, 64'h0000_0000_00A0_0123);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule